// File: doc/BRIEF.md
# Shared-Memory Mailbox With Ownership Handover

This block is a 256-bit message aperture that sits between a requesting function and a serving function. The aperture is split into eight 32-bit words. The requester fills the words over a simple register write port. Its write to the last word is the header write, and that write also hands the channel to the server. A flag in the top bit of the header word shows who owns the channel. The server is told that a message is waiting by a one-cycle ready pulse. It reads any word through its own read port. It then posts a response header in a single cycle, and that post returns the channel to the requester.

The block does not interpret the payload. The header word carries these fields, which the two sides use:
- bits [2:0]: message type
- bits [5:3]: version
- bit 7: direction, where 0 is a request and 1 is a response
- bits [15:8]: status, where 0 means success
- bit 24: function-reset request
- bit 31: owner flag, where 1 means the server owns the channel

The block itself acts only on bit 31. While the requester is held in reset, the requester's view of the header word reads as all ones. Its writes are then ignored.

Top module: `mbox_aperture`

## Requirements
- R1: After reset every word holds 0, the owner flag (header bit 31) is 0, and neither msgReady nor reqWrErr is asserted.
- R2: While the requester owns the channel, a requester write to words 0 to 6 stores the data. The data is readable on both read ports from the next cycle, and no msgReady pulse is raised.
- R3: While the requester owns the channel, a requester write to word 7 stores the data with bit 31 forced to 1, whatever value bit 31 carried. ownerIsSrv goes high from the next cycle.
- R4: A write accepted into word 7 raises msgReady for exactly one cycle, in the cycle after the write.
- R5: While the server owns the channel, any requester write is dropped: no word changes. reqWrErr pulses for exactly one cycle, in the cycle after the write.
- R6: While the server owns the channel, srvRspEn loads srvRspData into word 7 with bit 31 forced to 0. The requester owns the channel from the next cycle, and words 0 to 6 are unchanged.
- R7: A response posted while the requester owns the channel is ignored, and word 7 keeps its value.
- R8: While reqRstHold is high, a requester read of word 7 returns 0xFFFFFFFF. Requester writes are ignored without raising reqWrErr. The server read port still returns the stored value. Once reqRstHold drops, the stored value is visible again.
- R9: Both read ports are combinational and return the addressed word in the same cycle. A read has no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqRstHold | input | 1 | Requester held in reset |
| reqWrEn | input | 1 | Requester write strobe |
| reqAddr | input | 3 | Requester word index, used for both read and write |
| reqWrData | input | 32 | Requester write data |
| reqRdData | output | 32 | Requester read data |
| reqWrErr | output | 1 | One-cycle pulse for a dropped write |
| srvRdAddr | input | 3 | Server word index |
| srvRdData | output | 32 | Server read data |
| srvRspEn | input | 1 | Server response post strobe |
| srvRspData | input | 32 | Response header value |
| msgReady | output | 1 | One-cycle pulse when a message is handed over |
| ownerIsSrv | output | 1 | Channel owned by the server |

## Verification
A stuck or wrongly set owner flag is visible on ownerIsSrv and in bit 31 of word 7 on both read ports in the very next cycle. It also shows as a missing or spurious reqWrErr pulse on the following requester write. A write-enable decode error corrupts a neighbouring word. The bench catches this because it reads all eight words back after every scenario, so the error appears within one scenario. Pulse-timing errors in msgReady or reqWrErr are caught by sampling them in the one cycle after the triggering write, and again in the cycle after that.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int WORD_W    = 32;
  localparam int NUM_WORDS = 8;
  localparam int ADDR_W    = $clog2(NUM_WORDS);
  localparam int HDR_IDX   = NUM_WORDS - 1;
  localparam int OWN_BIT   = WORD_W - 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic              wordWr;  // accepted requester write
    logic [ADDR_W-1:0] wrIdx;   // target word
    logic              hdrRsp;  // server response load into header
  } mboxStrobe_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int NumWords = NUM_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqRstHold,
  input  logic              reqWrEn,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              srvRspEn,
  input  logic              ownerIsSrv,
  output mboxStrobe_t       strobe,
  output logic              msgReady,
  output logic              reqWrErr
);
  localparam logic [ADDR_W-1:0] HdrIdx = ADDR_W'(NumWords - 1);

  logic liveWr;
  logic acceptWr;
  logic dropWr;
  logic hdrHandover;

  always_comb begin
    liveWr      = reqWrEn && !reqRstHold;
    acceptWr    = liveWr && !ownerIsSrv;
    dropWr      = liveWr && ownerIsSrv;
    hdrHandover = acceptWr && (reqAddr == HdrIdx);
    strobe.wordWr = acceptWr;
    strobe.wrIdx  = reqAddr;
    strobe.hdrRsp = srvRspEn && ownerIsSrv;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      msgReady <= 1'b0;
      reqWrErr <= 1'b0;
    end else begin
      msgReady <= hdrHandover;
      reqWrErr <= dropWr;
    end
  end
endmodule

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
#(
  parameter int NumWords = NUM_WORDS,
  parameter int WordW    = WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  mboxStrobe_t       strobe,
  input  logic [WordW-1:0]  reqWrData,
  input  logic [WordW-1:0]  srvRspData,
  input  logic              reqRstHold,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [ADDR_W-1:0] srvRdAddr,
  output logic [WordW-1:0]  reqRdData,
  output logic [WordW-1:0]  srvRdData,
  output logic              ownerIsSrv
);
  localparam int OwnBit = WordW - 1;
  localparam logic [WordW-1:0] OwnMask = WordW'(1) << OwnBit;
  localparam logic [ADDR_W-1:0] HdrIdx = ADDR_W'(NumWords - 1);

  logic [WordW-1:0] words [NumWords];

  for (genvar gi = 0; gi < NumWords; gi++) begin : g_word
    logic [WordW-1:0] wordQ;
    logic hit;
    assign hit = strobe.wordWr && (strobe.wrIdx == ADDR_W'(gi));
    if (gi == NumWords - 1) begin : g_hdr
      always_ff @(posedge clk) begin
        if (!rstN)              wordQ <= '0;
        else if (strobe.hdrRsp) wordQ <= srvRspData & ~OwnMask;
        else if (hit)           wordQ <= reqWrData | OwnMask;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rstN)    wordQ <= '0;
        else if (hit) wordQ <= reqWrData;
      end
    end
    assign words[gi] = wordQ;
  end

  always_comb begin
    ownerIsSrv = words[NumWords-1][OwnBit];
    srvRdData  = words[srvRdAddr];
    if (reqRstHold && (reqAddr == HdrIdx)) reqRdData = '1;
    else                                   reqRdData = words[reqAddr];
  end
endmodule

// File: rtl/mbox_aperture.sv
module mbox_aperture
  import mbox_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqRstHold,
  input  logic              reqWrEn,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqWrData,
  output logic [WORD_W-1:0] reqRdData,
  output logic              reqWrErr,
  input  logic [ADDR_W-1:0] srvRdAddr,
  output logic [WORD_W-1:0] srvRdData,
  input  logic              srvRspEn,
  input  logic [WORD_W-1:0] srvRspData,
  output logic              msgReady,
  output logic              ownerIsSrv
);
  mboxStrobe_t strobe;

  mbox_ctrl #(.NumWords(NUM_WORDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqRstHold(reqRstHold), .reqWrEn(reqWrEn),
    .reqAddr(reqAddr), .srvRspEn(srvRspEn), .ownerIsSrv(ownerIsSrv),
    .strobe(strobe), .msgReady(msgReady), .reqWrErr(reqWrErr)
  );

  mbox_store #(.NumWords(NUM_WORDS), .WordW(WORD_W)) u_store (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrData(reqWrData),
    .srvRspData(srvRspData), .reqRstHold(reqRstHold), .reqAddr(reqAddr),
    .srvRdAddr(srvRdAddr), .reqRdData(reqRdData), .srvRdData(srvRdData),
    .ownerIsSrv(ownerIsSrv)
  );
endmodule

// File: rtl/mbox_aperture_chk.sv
module mbox_aperture_chk
  import mbox_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqRstHold,
  input logic              reqWrEn,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [WORD_W-1:0] reqRdData,
  input logic              reqWrErr,
  input logic [WORD_W-1:0] srvRdData,
  input logic [ADDR_W-1:0] srvRdAddr,
  input logic              srvRspEn,
  input logic              msgReady,
  input logic              ownerIsSrv
);
  localparam logic [ADDR_W-1:0] HdrIdx = ADDR_W'(HDR_IDX);

  p_own_set_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqWrEn && !reqRstHold && !ownerIsSrv && reqAddr == HdrIdx) |=> ownerIsSrv);

  p_ready_owner_r4: assert property (@(posedge clk) disable iff (!rstN)
    msgReady |-> ownerIsSrv);

  p_ready_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    msgReady |=> !msgReady);

  p_drop_err_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqWrEn && !reqRstHold && ownerIsSrv) |=> (reqWrErr && !msgReady));

  p_drop_keeps_word_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqWrEn && !reqRstHold && ownerIsSrv && !srvRspEn && reqAddr == srvRdAddr)
      |=> (srvRdData == $past(srvRdData)) || !$stable(srvRdAddr));

  p_rsp_release_r6: assert property (@(posedge clk) disable iff (!rstN)
    (srvRspEn && ownerIsSrv) |=> !ownerIsSrv);

  p_rsp_ignored_r7: assert property (@(posedge clk) disable iff (!rstN)
    (srvRspEn && !ownerIsSrv && !reqWrEn) |=> !ownerIsSrv);

  p_hold_ones_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqRstHold && reqAddr == HdrIdx) |-> (reqRdData == '1));

  p_hold_no_err_r8: assert property (@(posedge clk) disable iff (!rstN)
    reqRstHold |=> !reqWrErr && !msgReady);
endmodule

bind mbox_aperture mbox_aperture_chk u_chk (
  .clk(clk), .rstN(rstN), .reqRstHold(reqRstHold), .reqWrEn(reqWrEn),
  .reqAddr(reqAddr), .reqRdData(reqRdData), .reqWrErr(reqWrErr),
  .srvRdData(srvRdData), .srvRdAddr(srvRdAddr), .srvRspEn(srvRspEn),
  .msgReady(msgReady), .ownerIsSrv(ownerIsSrv)
);

// File: tb/mbox_aperture_bench.sv
module mbox_aperture_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqRstHold = 1'b0;
  logic        reqWrEn = 1'b0;
  logic [2:0]  reqAddr = '0;
  logic [31:0] reqWrData = '0;
  logic [31:0] reqRdData;
  logic        reqWrErr;
  logic [2:0]  srvRdAddr = '0;
  logic [31:0] srvRdData;
  logic        srvRspEn = 1'b0;
  logic [31:0] srvRspData = '0;
  logic        msgReady;
  logic        ownerIsSrv;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [8];

  always #5 clk = ~clk;

  mbox_aperture u_mbox_aperture (
    .clk(clk), .rstN(rstN), .reqRstHold(reqRstHold), .reqWrEn(reqWrEn),
    .reqAddr(reqAddr), .reqWrData(reqWrData), .reqRdData(reqRdData),
    .reqWrErr(reqWrErr), .srvRdAddr(srvRdAddr), .srvRdData(srvRdData),
    .srvRspEn(srvRspEn), .srvRspData(srvRspData), .msgReady(msgReady),
    .ownerIsSrv(ownerIsSrv)
  );

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Read all words through both ports and compare with the model
  task automatic check_all(string req);
    for (int i = 0; i < 8; i++) begin
      reqAddr = 3'(i);
      srvRdAddr = 3'(i);
      #1;
      check(req, $sformatf("req word %0d", i), reqRdData, model[i]);
      check(req, $sformatf("srv word %0d", i), srvRdData, model[i]);
    end
  endtask

  task automatic req_write(logic [2:0] a, logic [31:0] d);
    reqAddr = a; reqWrData = d; reqWrEn = 1'b1;
    step();
    reqWrEn = 1'b0;
  endtask

  task automatic srv_post(logic [31:0] d);
    srvRspData = d; srvRspEn = 1'b1;
    step();
    srvRspEn = 1'b0;
  endtask

  task automatic t_reset();
    for (int i = 0; i < 8; i++) model[i] = '0;
    check("R1", "ownerIsSrv", 32'(ownerIsSrv), 0);
    check("R1", "msgReady", 32'(msgReady), 0);
    check("R1", "reqWrErr", 32'(reqWrErr), 0);
    check_all("R1");
  endtask

  task automatic t_fill();
    for (int i = 0; i < 7; i++) begin
      req_write(3'(i), 32'hA5000000 ^ (32'(i) * 32'h01010101) ^ 32'h80000000);
      model[i] = 32'hA5000000 ^ (32'(i) * 32'h01010101) ^ 32'h80000000;
      check("R2", "no msgReady on body write", 32'(msgReady), 0);
      check("R2", "owner stays requester", 32'(ownerIsSrv), 0);
    end
    check_all("R2 R9");
  endtask

  task automatic t_handover(logic [31:0] hdr);
    req_write(3'd7, hdr);
    model[7] = hdr | 32'h80000000;
    check("R3", "ownerIsSrv", 32'(ownerIsSrv), 1);
    check("R4", "msgReady pulse", 32'(msgReady), 1);
    check("R4", "no error", 32'(reqWrErr), 0);
    step();
    check("R4", "msgReady single cycle", 32'(msgReady), 0);
    check_all("R3");
  endtask

  task automatic t_drop();
    req_write(3'd2, 32'h12345678);
    check("R5", "reqWrErr pulse", 32'(reqWrErr), 1);
    check("R5", "no msgReady", 32'(msgReady), 0);
    step();
    check("R5", "reqWrErr single cycle", 32'(reqWrErr), 0);
    req_write(3'd7, 32'h00000002);
    check("R5", "reqWrErr on header", 32'(reqWrErr), 1);
    check("R5", "no msgReady on header", 32'(msgReady), 0);
    check_all("R5");
  endtask

  task automatic t_response(logic [31:0] rsp);
    srv_post(rsp);
    model[7] = rsp & 32'h7FFFFFFF;
    check("R6", "ownerIsSrv released", 32'(ownerIsSrv), 0);
    check_all("R6");
  endtask

  task automatic t_ignored();
    srv_post(32'hDEAD0081);
    check("R7", "owner unchanged", 32'(ownerIsSrv), 0);
    check_all("R7");
  endtask

  task automatic t_hold();
    reqRstHold = 1'b1;
    reqAddr = 3'd7; srvRdAddr = 3'd7;
    #1;
    check("R8", "req word 7 all ones", reqRdData, 32'hFFFFFFFF);
    check("R8", "srv word 7 stored", srvRdData, model[7]);
    reqAddr = 3'd3;
    #1;
    check("R8", "req word 3 normal", reqRdData, model[3]);
    req_write(3'd3, 32'h0BADF00D);
    check("R8", "no error in hold", 32'(reqWrErr), 0);
    req_write(3'd7, 32'h00000001);
    check("R8", "no handover in hold", 32'(msgReady), 0);
    check("R8", "owner unchanged in hold", 32'(ownerIsSrv), 0);
    reqRstHold = 1'b0;
    check_all("R8");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    rstN = 1'b1;
    step();
    t_reset();
    t_fill();
    t_handover(32'h01000001);
    t_drop();
    t_response(32'h80000181);
    t_ignored();
    t_handover(32'h80000002);
    t_response(32'h00000082);
    t_hold();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule